// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Unit

This block turns the input levels of three 8-bit GPIO ports into interrupt requests. Every pin can be set to sense a level or an edge, with a per-pin polarity, and can be masked one by one. Edge events are held in a sticky pending bit until software acknowledges them by writing ones to a clear register. Level requests are not held; they follow the sampled pin for as long as it stays at the active level.

Each raw pin passes through a two-flop synchroniser. An optional per-pin debounce filter then accepts a new level only after it has held for a set number of consecutive filter ticks. The first two ports (A and B) share one combined request line. Each of the eight pins of the third port (F) drives its own request line. Software configures the block through a simple byte-wide register bus. Writes take effect on a single-cycle strobe, and reads return data combinationally from the address.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register, every pending bit, `irq_ab` and `irq_f` are 0, and the status registers read 0.
- R2: With the trigger-type bit at 0 (level), an enabled pin's status bit is 1 exactly while the sampled pin equals its polarity bit (polarity 1 = high, 0 = low).
- R3: With the trigger-type bit at 1 (edge), a rising transition (polarity 1) or falling transition (polarity 0) of the sampled pin sets a pending bit. The bit stays set while no end-of-interrupt write selects it.
- R4: Writing a byte to a port's end-of-interrupt register clears the pending bits at the positions written as 1 and leaves the positions written as 0 unchanged.
- R5: A pin whose enable bit is 0 reports status 0 and latches nothing. Clearing the enable bit drops its pending bit. Polarity writes or pin changes made while a pin is disabled leave no pending bit once it is enabled again.
- R6: If an edge and an end-of-interrupt write reach the same pin in the same cycle, the pending bit stays set.
- R7: With the debounce bit at 1, a changed level reaches the detector only after DB_TICKS consecutive cycles with `tick_en` high (default 4). Shorter pulses are dropped, and no level is accepted while `tick_en` is low. With the bit at 0 the synchronised pin is used directly.
- R8: `irq_ab` is the OR of all status bits of ports A and B.
- R9: `irq_f[i]` equals status bit i of port F.
- R10: Register byte addresses, for ports A/B/F: trigger type 0x90/0xAC/0x4C, polarity 0x94/0xB0/0x50, end-of-interrupt 0x98/0xB4/0x54, enable 0x9C/0xB8/0x58, debounce 0xA8/0xC4/0x64, status 0xA0/0xBC/0x5C. Configuration registers read back what was written. End-of-interrupt registers read as 0. Writes to status registers have no effect. Bit i of each register belongs to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Debounce filter tick enable |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pin_a | input | 8 | Raw port A pins |
| pin_b | input | 8 | Raw port B pins |
| pin_f | input | 8 | Raw port F pins |
| irq_ab | output | 1 | Combined request of ports A and B |
| irq_f | output | 8 | Per-pin requests of port F |

## Verification
The hardest case to reach from the ports is an edge and an end-of-interrupt write landing on the same clock edge, because the edge appears only after the synchroniser's latency. The bench sets a pin exactly two falling clock edges before it raises the write strobe. The detector then sees the transition in the same cycle the strobe is sampled, and the bench checks that the pending bit survives. Debounce rejection is reached the same way. The bench makes pulses shorter than the filter window and holds a level while `tick_en` is low, so the filter counter never completes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DW    = 8;
  localparam int NPORT = 3;

  typedef enum logic [1:0] { PORT_A = 2'd0, PORT_B = 2'd1, PORT_F = 2'd2 } port_e;

  typedef logic [NPORT-1:0][DW-1:0] port_vec_t;

  // byte addresses per port, index order A, B, F
  localparam logic [7:0] OFF_TRIG [NPORT] = '{8'h90, 8'hAC, 8'h4C};
  localparam logic [7:0] OFF_POL  [NPORT] = '{8'h94, 8'hB0, 8'h50};
  localparam logic [7:0] OFF_EOI  [NPORT] = '{8'h98, 8'hB4, 8'h54};
  localparam logic [7:0] OFF_EN   [NPORT] = '{8'h9C, 8'hB8, 8'h58};
  localparam logic [7:0] OFF_DB   [NPORT] = '{8'hA8, 8'hC4, 8'h64};
  localparam logic [7:0] OFF_STAT [NPORT] = '{8'hA0, 8'hBC, 8'h5C};
endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter #(
  parameter int DB_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic pin_raw,
  input  logic db_en,
  output logic level
);
  localparam int CW = $clog2(DB_TICKS + 1);

  logic          sync1_q, sync2_q;
  logic          stable_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= 1'b0;
      sync2_q  <= 1'b0;
      stable_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sync1_q <= pin_raw;
      sync2_q <= sync1_q;
      if (!db_en) begin
        // track the raw sample so enabling the filter causes no jump
        stable_q <= sync2_q;
        cnt_q    <= '0;
      end else if (tick_en) begin
        if (sync2_q == stable_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(DB_TICKS - 1)) begin
          stable_q <= sync2_q;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign level = db_en ? stable_q : sync2_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int W        = 8,
  parameter int DB_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] pin_in,
  input  logic         wr_trig,
  input  logic         wr_pol,
  input  logic         wr_eoi,
  input  logic         wr_en,
  input  logic         wr_db,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] trig_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] db_q,
  output logic [W-1:0] stat
);
  logic [W-1:0] samp, prev_q, pend_q, pend_d;
  logic [W-1:0] rise, fall, edge_hit, eoi_clr, level_hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    gpio_pin_filter #(.DB_TICKS(DB_TICKS)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .pin_raw (pin_in[i]),
      .db_en   (db_q[i]),
      .level   (samp[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      db_q   <= '0;
    end else begin
      if (wr_trig) trig_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      if (wr_en)   en_q   <= wdata;
      if (wr_db)   db_q   <= wdata;
    end
  end

  // transitions are taken on the unpolarised sample, so a polarity
  // write alone never looks like an edge
  always_comb begin
    rise      = samp & ~prev_q;
    fall      = ~samp & prev_q;
    edge_hit  = (pol_q & rise) | (~pol_q & fall);
    eoi_clr   = wr_eoi ? wdata : '0;
    pend_d    = en_q & trig_q & ((pend_q & ~eoi_clr) | edge_hit);
    level_hit = en_q & ~trig_q & ~(samp ^ pol_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= samp;
      pend_q <= pend_d;
    end
  end

  assign stat = pend_q | level_hit;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int DB_TICKS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [7:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [DW-1:0] pin_a,
  input  logic [DW-1:0] pin_b,
  input  logic [DW-1:0] pin_f,
  output logic          irq_ab,
  output logic [DW-1:0] irq_f
);
  port_vec_t            pins_v, trig_v, pol_v, en_v, db_v, stat_v;
  logic [NPORT-1:0]     port_wr_v;

  assign pins_v[PORT_A] = pin_a;
  assign pins_v[PORT_B] = pin_b;
  assign pins_v[PORT_F] = pin_f;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hit_trig, hit_pol, hit_eoi, hit_en, hit_db;
    assign hit_trig = reg_wr && (reg_addr == OFF_TRIG[p]);
    assign hit_pol  = reg_wr && (reg_addr == OFF_POL[p]);
    assign hit_eoi  = reg_wr && (reg_addr == OFF_EOI[p]);
    assign hit_en   = reg_wr && (reg_addr == OFF_EN[p]);
    assign hit_db   = reg_wr && (reg_addr == OFF_DB[p]);
    assign port_wr_v[p] = hit_trig | hit_pol | hit_eoi | hit_en | hit_db;

    gpio_irq_port #(.W(DW), .DB_TICKS(DB_TICKS)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .pin_in  (pins_v[p]),
      .wr_trig (hit_trig),
      .wr_pol  (hit_pol),
      .wr_eoi  (hit_eoi),
      .wr_en   (hit_en),
      .wr_db   (hit_db),
      .wdata   (reg_wdata),
      .trig_q  (trig_v[p]),
      .pol_q   (pol_v[p]),
      .en_q    (en_v[p]),
      .db_q    (db_v[p]),
      .stat    (stat_v[p])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (reg_addr == OFF_TRIG[p]) reg_rdata = trig_v[p];
      if (reg_addr == OFF_POL[p])  reg_rdata = pol_v[p];
      if (reg_addr == OFF_EN[p])   reg_rdata = en_v[p];
      if (reg_addr == OFF_DB[p])   reg_rdata = db_v[p];
      if (reg_addr == OFF_STAT[p]) reg_rdata = stat_v[p];
    end
  end

  assign irq_ab = (|stat_v[PORT_A]) | (|stat_v[PORT_B]);
  assign irq_f  = stat_v[PORT_F];
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
  import gpio_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             irq_ab,
  input logic [DW-1:0]    irq_f,
  input port_vec_t        stat_v,
  input port_vec_t        trig_v,
  input port_vec_t        en_v,
  input logic [NPORT-1:0] port_wr_v
);
  for (genvar p = 0; p < NPORT; p++) begin : g_p
    for (genvar i = 0; i < DW; i++) begin : g_i
      // R3: a pending edge stays while its port sees no register write
      assert_sticky_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_v[p][i] && en_v[p][i] && stat_v[p][i] && !port_wr_v[p]) |=> stat_v[p][i]);
      // R5: nothing is pending in edge mode right after a disabled cycle
      assert_no_pend_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en_v[p][i]) && trig_v[p][i]) |-> !stat_v[p][i]);
    end
  end

  assert_irq_ab_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ab |-> ((|stat_v[PORT_A]) || (|stat_v[PORT_B])));

  assert_irq_f_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_f == stat_v[PORT_F]);
endmodule

bind gpio_irq_unit gpio_irq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_ab    (irq_ab),
  .irq_f     (irq_f),
  .stat_v    (stat_v),
  .trig_v    (trig_v),
  .en_v      (en_v),
  .port_wr_v (port_wr_v)
);

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] pin_a = '0, pin_b = '0, pin_f = '0;
  logic       irq_ab;
  logic [7:0] irq_f;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_a(pin_a), .pin_b(pin_b), .pin_f(pin_f),
    .irq_ab(irq_ab), .irq_f(irq_f)
  );

  // {trig, pol, en, pins, expected status} for port A, level mode
  localparam logic [39:0] VEC [8] = '{
    {8'h00, 8'hFF, 8'hFF, 8'hA5, 8'hA5},
    {8'h00, 8'h00, 8'hFF, 8'hA5, 8'h5A},
    {8'h00, 8'h0F, 8'hFF, 8'h33, 8'hC3},
    {8'h00, 8'hFF, 8'h0F, 8'hFF, 8'h0F},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'hAA, 8'hFF, 8'hAA, 8'hFF},
    {8'h00, 8'hAA, 8'hF0, 8'h55, 8'h00},
    {8'h00, 8'hFF, 8'h81, 8'h81, 8'h81}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    rdchk("R1 stat A", 8'hA0, 8'h00);
    rdchk("R1 stat B", 8'hBC, 8'h00);
    rdchk("R1 stat F", 8'h5C, 8'h00);
    rdchk("R1 en A", 8'h9C, 8'h00);
    rdchk("R1 trig F", 8'h4C, 8'h00);
    chk("R1 irq_ab", {7'd0, irq_ab}, 8'h00);
    chk("R1 irq_f", irq_f, 8'h00);

    // R2 / R8 level table walk on port A
    for (int k = 0; k < 8; k++) begin
      wr(8'h90, VEC[k][39:32]);
      wr(8'h94, VEC[k][31:24]);
      wr(8'h9C, VEC[k][23:16]);
      pin_a = VEC[k][15:8];
      cyc(5);
      rdchk("R2 level status A", 8'hA0, VEC[k][7:0]);
      chk("R8 irq_ab from A", {7'd0, irq_ab}, {7'd0, |VEC[k][7:0]});
    end
    wr(8'h9C, 8'h00);
    pin_a = 8'h00;
    cyc(5);

    // R10 map and readback
    wr(8'hAC, 8'h3C);
    rdchk("R10 trig B readback", 8'hAC, 8'h3C);
    wr(8'h50, 8'h96);
    rdchk("R10 pol F readback", 8'h50, 8'h96);
    wr(8'hC4, 8'h5A);
    rdchk("R10 db B readback", 8'hC4, 8'h5A);
    wr(8'hC4, 8'h00);
    wr(8'hA0, 8'hFF);
    rdchk("R10 status write ignored", 8'hA0, 8'h00);
    rdchk("R10 eoi reads zero", 8'hB4, 8'h00);

    // R3 edge on port B
    wr(8'hAC, 8'hFF);
    wr(8'hB0, 8'h0F);
    wr(8'hB8, 8'hFF);
    pin_b = 8'hFF;
    cyc(5);
    rdchk("R3 rising latched", 8'hBC, 8'h0F);
    pin_b = 8'h00;
    cyc(5);
    rdchk("R3 falling latched", 8'hBC, 8'hFF);
    pin_b = 8'hFF;
    cyc(5);
    rdchk("R3 sticky", 8'hBC, 8'hFF);
    chk("R8 irq_ab from B", {7'd0, irq_ab}, 8'h01);

    // R4 write-one clear
    wr(8'hB4, 8'h55);
    cyc(1);
    rdchk("R4 partial clear", 8'hBC, 8'hAA);
    wr(8'hB4, 8'hAA);
    cyc(1);
    rdchk("R4 full clear", 8'hBC, 8'h00);
    chk("R8 irq_ab idle", {7'd0, irq_ab}, 8'h00);

    // R5 disabled pins latch nothing
    wr(8'hB8, 8'h00);
    pin_b = 8'h00;
    cyc(3);
    wr(8'hB0, 8'hF0);
    wr(8'hB0, 8'h0F);
    wr(8'hB0, 8'hF0);
    cyc(3);
    wr(8'hB8, 8'hFF);
    cyc(3);
    rdchk("R5 no spurious latch", 8'hBC, 8'h00);
    pin_b = 8'hFF;
    cyc(5);
    rdchk("R5 live after enable", 8'hBC, 8'hF0);
    wr(8'hB8, 8'h00);
    wr(8'hB8, 8'hFF);
    cyc(1);
    rdchk("R5 disable drops pending", 8'hBC, 8'h00);
    wr(8'hB8, 8'h00);

    // R6 / R9 collision on port F pin 0
    wr(8'h4C, 8'h01);
    wr(8'h50, 8'h01);
    wr(8'h58, 8'h01);
    pin_f = 8'h01;
    cyc(5);
    chk("R9 irq_f edge", irq_f, 8'h01);
    pin_f = 8'h00;
    cyc(5);
    chk("R3 falling ignored pol1", irq_f, 8'h01);
    pin_f = 8'h01;
    cyc(2);
    reg_addr = 8'h54; reg_wdata = 8'h01; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    cyc(2);
    rdchk("R6 edge beats eoi", 8'h5C, 8'h01);
    wr(8'h54, 8'h01);
    cyc(1);
    rdchk("R4 eoi alone clears", 8'h5C, 8'h00);
    wr(8'h4C, 8'h00);
    wr(8'h50, 8'h09);
    wr(8'h58, 8'h09);
    pin_f = 8'h08;
    cyc(5);
    chk("R9 irq_f level pin3", irq_f, 8'h08);
    wr(8'h58, 8'h00);
    pin_f = 8'h00;

    // R7 debounce on port A pin 0
    wr(8'h90, 8'h01);
    wr(8'h94, 8'h01);
    wr(8'hA8, 8'h01);
    wr(8'h9C, 8'h01);
    cyc(3);
    pin_a = 8'h01; cyc(2); pin_a = 8'h00;
    cyc(10);
    rdchk("R7 short pulse filtered", 8'hA0, 8'h00);
    tick_en = 1'b0;
    pin_a = 8'h01;
    cyc(12);
    rdchk("R7 no ticks no accept", 8'hA0, 8'h00);
    tick_en = 1'b1;
    cyc(3);
    rdchk("R7 too few ticks", 8'hA0, 8'h00);
    cyc(6);
    rdchk("R7 long level accepted", 8'hA0, 8'h01);
    wr(8'h98, 8'h01);
    pin_a = 8'h00;
    cyc(12);
    wr(8'hA8, 8'h00);
    cyc(2);
    pin_a = 8'h01; cyc(2); pin_a = 8'h00;
    cyc(5);
    rdchk("R7 raw short pulse seen", 8'hA0, 8'h01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule